// File: doc/BRIEF.md
# Record-Path G.711 Compressor

This block sits between the capture path of an audio converter and the serial shifter that sends samples out. It takes a 16-bit two's-complement sample with a one-cycle valid strobe. It returns a 16-bit word for the shifter, registered one clock after the strobe. Two control inputs choose the format of that word: a compression enable and a law select.

With compression on, the law select picks μ-law (0) or A-law (1). The block encodes the sample into an 8-bit G.711 code and places it in the top byte of the word, with the low byte cleared. With compression off, the law select picks between two uncompressed formats. A value of 1 gives a narrow 8-bit format, which is the top byte of the sample. A value of 0 passes the full 16-bit sample through unchanged.

The μ-law path works on the 14 most significant sample bits, a 13-bit magnitude plus sign. The A-law path works on the 13 most significant bits, a 12-bit magnitude plus sign. The encoding logic is combinational, and a single output register holds the result until the next strobe.

Top module: `g711_rec_compressor`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `word_o` is 0 and `word_vld_o` is 0.
- R2: `word_vld_o` is 1 in exactly the clock cycle that follows a cycle with `smp_vld_i` = 1, and 0 otherwise.
- R3: In a cycle with `smp_vld_i` = 0 the output word keeps its previous value, whatever the sample and control inputs do.
- R4: With `cmp_en_i` = 1 and `law_sel_i` = 0, the code is μ-law, formed as follows. Let x be the sample arithmetically shifted right by 2, and let m be the magnitude of x, limited to 8158. Then b = m + 33. The exponent e is the index of the leading one of b minus 5. The mantissa is bits e+4 down to e+1 of b. The code is the bitwise complement of {sign(x<0), e, mantissa}.
- R5: With `cmp_en_i` = 1 and `law_sel_i` = 1, the code is A-law, formed as follows. Let x be the sample arithmetically shifted right by 3. Let m = x for x >= 0, and m = -x-1 for x < 0. For m < 32, e = 0 and the mantissa is m/2. Otherwise e is the index of the leading one of m minus 4, and the mantissa is bits e+3 down to e of m. The code is {x>=0, e, mantissa} XOR 0x55.
- R6: In both compressed modes the 8-bit code is carried in `word_o[15:8]`, laid out as sign in bit 15, exponent in bits 14:12 and mantissa in bits 11:8. `word_o[7:0]` is 0.
- R7: With `cmp_en_i` = 0 and `law_sel_i` = 1, `word_o` equals {sample[15:8], 8'h00}.
- R8: With `cmp_en_i` = 0 and `law_sel_i` = 0, `word_o` equals the sample unchanged.
- R9: A zero sample encodes to 0xFF in μ-law and to 0xD5 in A-law. The most negative sample encodes to 0x00 in μ-law and to 0x2A in A-law.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_i | input | 16 | Linear two's-complement sample |
| smp_vld_i | input | 1 | Sample strobe, loads the output register |
| cmp_en_i | input | 1 | Compression enable |
| law_sel_i | input | 1 | Law select: μ-law/A-law when enabled, 16-bit/8-bit when disabled |
| word_o | output | 16 | Word for the serial shifter, MSB-justified in 8-bit modes |
| word_vld_o | output | 1 | High for one cycle when `word_o` has been updated |

## Verification
The only state in the block is the output register, its valid flag and the reset synchronizer. A fault in the register or the valid flag shows up at the ports on the cycle right after a strobe, either as a wrong or stale word or as a misplaced valid pulse. A fault in the combinational encoders shows up only for the sample values whose segment or mantissa path it damages. For that reason, every 16-bit sample is swept through both compressed modes and compared against an arithmetic model one cycle after its strobe. The two uncompressed modes are swept with a stride.

// File: rtl/g711c_pkg.sv
package g711c_pkg;
  // linear sample and code widths
  localparam int SMP_W  = 16;
  localparam int CODE_W = 8;
  localparam int LOW_W  = SMP_W - CODE_W;
  // significant input bits for each law (magnitude + sign)
  localparam int MU_IN_W = 14;
  localparam int A_IN_W  = 13;
  localparam int MU_DROP = SMP_W - MU_IN_W;
  localparam int A_DROP  = SMP_W - A_IN_W;
  // mu-law bias and magnitude ceiling so that biased value fits 13 bits
  localparam int MU_BIAS = 33;
  localparam int MU_CLIP = 8158;
  // inversion masks
  localparam logic [CODE_W-1:0] MU_INV = 8'hFF;
  localparam logic [CODE_W-1:0] A_INV  = 8'h55;

  typedef enum logic [1:0] {
    FMT_LINEAR16 = 2'b00,
    FMT_TRUNC8   = 2'b01,
    FMT_MULAW    = 2'b10,
    FMT_ALAW     = 2'b11
  } fmt_e;
endpackage

// File: rtl/g711c_rst_sync.sv
module g711c_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/g711c_mulaw_enc.sv
module g711c_mulaw_enc
  import g711c_pkg::*;
(
  input  logic [MU_IN_W-1:0] lin_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int MAG_W = MU_IN_W - 1;

  logic             neg;
  logic [MU_IN_W-1:0] mag;
  logic [MAG_W-1:0] clipped;
  logic [MAG_W-1:0] biased;
  logic [2:0]       expo;
  logic [3:0]       mant;

  always_comb begin
    neg = lin_i[MU_IN_W-1];
    mag = neg ? (~lin_i + 1'b1) : lin_i;
    clipped = (mag > MU_IN_W'(MU_CLIP)) ? MAG_W'(MU_CLIP) : mag[MAG_W-1:0];
    biased = clipped + MAG_W'(MU_BIAS);
    // leading-one search over bits 5..12, highest set bit wins
    expo = 3'd0;
    for (int b = 5; b < MAG_W; b++) begin
      if (biased[b]) expo = 3'(b - 5);
    end
    mant = biased[({1'b0, expo} + 4'd1) +: 4];
    code_o = {neg, expo, mant} ^ MU_INV;
  end
endmodule

// File: rtl/g711c_alaw_enc.sv
module g711c_alaw_enc
  import g711c_pkg::*;
(
  input  logic [A_IN_W-1:0] lin_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int MAG_W = A_IN_W - 1;

  logic             neg;
  logic [MAG_W-1:0] mag;
  logic [2:0]       expo;
  logic [3:0]       mant;

  always_comb begin
    neg = lin_i[A_IN_W-1];
    // one's complement folds negatives onto 0..4095
    mag = neg ? ~lin_i[MAG_W-1:0] : lin_i[MAG_W-1:0];
    expo = 3'd0;
    for (int b = 5; b < MAG_W; b++) begin
      if (mag[b]) expo = 3'(b - 4);
    end
    if (expo == 3'd0) mant = 4'(mag[4:0] >> 1);
    else              mant = mag[expo +: 4];
    code_o = {~neg, expo, mant} ^ A_INV;
  end
endmodule

// File: rtl/g711c_out_reg.sv
module g711c_out_reg
  import g711c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [SMP_W-1:0] data_i,
  output logic [SMP_W-1:0] word_o,
  output logic             vld_o
);
  logic [SMP_W-1:0] word_d, word_q;
  logic             vld_d, vld_q;

  always_comb begin
    word_d = word_q;
    if (ld_i) word_d = data_i;
    vld_d = ld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (ld_i) word_q <= word_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // R2
  vld_follows_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> vld_o);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> !vld_o);
  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(word_o));
  // R2 R3
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (word_o == $past(data_i)));
endmodule

// File: rtl/g711_rec_compressor.sv
module g711_rec_compressor
  import g711c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             smp_vld_i,
  input  logic             cmp_en_i,
  input  logic             law_sel_i,
  output logic [SMP_W-1:0] word_o,
  output logic             word_vld_o
);
  logic             rst_sync_n;
  logic [CODE_W-1:0] mu_code;
  logic [CODE_W-1:0] a_code;
  logic [SMP_W-1:0]  word_nxt;
  fmt_e              fmt;

  g711c_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  g711c_mulaw_enc u_mulaw (
    .lin_i  (smp_i[SMP_W-1:MU_DROP]),
    .code_o (mu_code)
  );

  g711c_alaw_enc u_alaw (
    .lin_i  (smp_i[SMP_W-1:A_DROP]),
    .code_o (a_code)
  );

  always_comb begin
    fmt = fmt_e'({cmp_en_i, law_sel_i});
    case (fmt)
      FMT_MULAW:  word_nxt = {mu_code, {LOW_W{1'b0}}};
      FMT_ALAW:   word_nxt = {a_code, {LOW_W{1'b0}}};
      FMT_TRUNC8: word_nxt = {smp_i[SMP_W-1:LOW_W], {LOW_W{1'b0}}};
      default:    word_nxt = smp_i;
    endcase
  end

  g711c_out_reg u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld_i   (smp_vld_i),
    .data_i (word_nxt),
    .word_o (word_o),
    .vld_o  (word_vld_o)
  );

  // R6
  low_byte_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (word_vld_o && $past(cmp_en_i)) |-> (word_o[LOW_W-1:0] == '0));
  // R7
  trunc8_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (word_vld_o && $past(!cmp_en_i && law_sel_i)) |->
      (word_o == {$past(smp_i[SMP_W-1:LOW_W]), {LOW_W{1'b0}}}));
  // R8
  linear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (word_vld_o && $past(!cmp_en_i && !law_sel_i)) |-> (word_o == $past(smp_i)));
endmodule

// File: tb/g711_rec_compressor_test.sv
`timescale 1ns/1ps
module g711_rec_compressor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] smp_i;
  logic        smp_vld_i;
  logic        cmp_en_i;
  logic        law_sel_i;
  logic [15:0] word_o;
  logic        word_vld_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  g711_rec_compressor uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_i      (smp_i),
    .smp_vld_i  (smp_vld_i),
    .cmp_en_i   (cmp_en_i),
    .law_sel_i  (law_sel_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

  function automatic int mu_ref(input int s);
    int x, m, b, seg, sgn;
    x = s >>> 2;
    sgn = (x < 0) ? 1 : 0;
    m = (x < 0) ? -x : x;
    if (m > 8158) m = 8158;
    b = m + 33;
    seg = 0;
    while (b >= (64 << seg)) seg++;
    return 255 - (sgn * 128 + seg * 16 + ((b >> (seg + 1)) % 16));
  endfunction

  function automatic int a_ref(input int s);
    int x, m, seg, sgn, mant;
    x = s >>> 3;
    if (x < 0) begin m = -x - 1; sgn = 0; end
    else       begin m = x;      sgn = 1; end
    if (m < 32) begin
      seg = 0; mant = m / 2;
    end else begin
      seg = 1;
      while (m >= (32 << seg)) seg++;
      mant = (m >> seg) % 16;
    end
    return (sgn * 128 + seg * 16 + mant) ^ 8'h55;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, output register loads at the next posedge,
  // sample at the negedge after that
  task automatic apply(input logic [15:0] s, input logic en, input logic sel);
    smp_i = s; cmp_en_i = en; law_sel_i = sel; smp_vld_i = 1'b1;
    @(negedge clk);
    smp_vld_i = 1'b0;
  endtask

  function automatic int expect_word(input int s, input logic en, input logic sel);
    int u;
    u = s & 16'hFFFF;
    if (en && !sel) return mu_ref(s) * 256;
    if (en && sel)  return a_ref(s) * 256;
    if (!en && sel) return (u / 256) * 256;
    return u;
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int last;
    rst_n = 1'b0; smp_i = 16'h1234; smp_vld_i = 1'b0; cmp_en_i = 1'b0; law_sel_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", word_o, 0);
    check("R1", word_vld_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release, before any strobe
    check("R1", word_o, 0);
    check("R1", word_vld_o, 0);

    // R9 corner codes
    apply(16'h0000, 1'b1, 1'b0); check("R9", word_o, 16'hFF00);
    apply(16'h0000, 1'b1, 1'b1); check("R9", word_o, 16'hD500);
    apply(16'h8000, 1'b1, 1'b0); check("R9", word_o, 16'h0000);
    apply(16'h8000, 1'b1, 1'b1); check("R9", word_o, 16'h2A00);

    // R2 pulse width and R3 hold with changing inputs
    apply(16'h4321, 1'b0, 1'b0);
    check("R2", word_vld_o, 1);
    smp_i = 16'hBEEF; cmp_en_i = 1'b1; law_sel_i = 1'b1;
    @(negedge clk);
    check("R2", word_vld_o, 0);
    check("R3", word_o, 16'h4321);
    smp_i = 16'h0F0F; cmp_en_i = 1'b0;
    @(negedge clk);
    check("R3", word_o, 16'h4321);

    // R4 R6 full mu-law sweep
    for (int s = -32768; s < 32768; s++) begin
      apply(16'(s), 1'b1, 1'b0);
      check("R4", word_o, expect_word(s, 1'b1, 1'b0));
      check("R2", word_vld_o, 1);
    end
    // R5 R6 full A-law sweep
    for (int s = -32768; s < 32768; s++) begin
      apply(16'(s), 1'b1, 1'b1);
      check("R5", word_o, expect_word(s, 1'b1, 1'b1));
    end
    // R6 low byte check on an odd sample
    apply(16'h7FFF, 1'b1, 1'b1);
    check("R6", word_o & 16'h00FF, 0);
    check("R6", word_o, 16'hAA00);
    // R7 truncated 8-bit sweep
    for (int s = -32768; s < 32768; s += 7) begin
      apply(16'(s), 1'b0, 1'b1);
      check("R7", word_o, expect_word(s, 1'b0, 1'b1));
    end
    // R8 linear passthrough sweep
    for (int s = -32768; s < 32768; s += 7) begin
      apply(16'(s), 1'b0, 1'b0);
      check("R8", word_o, expect_word(s, 1'b0, 1'b0));
    end
    last = word_o;
    @(negedge clk);
    // R3 final hold
    check("R3", word_o, last);
    check("R2", word_vld_o, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule